// File: doc/BRIEF.md
# SPI EEPROM Block Sequencer

This block is an SPI master that moves whole 256-byte blocks between a byte-wide buffer port and a serial EEPROM. A host gives it a single command: a read or a write, with a 16-bit block index. The sequencer then runs every chip-select frame the operation needs and pulses `done` once the operation is finished. A block read is a single frame. The data bytes it returns are written into the buffer at offsets 0 to 255.

A block write takes several frames in a fixed order:

1. A status read.
2. A status write that drops the protection bits, sent only if any of them was set.
3. A separate write-enable frame.
4. The data frame.
5. Status reads, repeated until the device reports that its internal write has finished.

A byte counts as transferred only when its eighth bit has been received, not when it has been sent. Every chip-select transition has a short guard delay before and after it. The serial clock rate comes from a divider input. Each clock phase lasts `clk_div+1` system cycles.

Top module: `eeprom_block_sequencer`

## Requirements
- R1: Reset state: `busy`=0, `done`=0, `spi_cs_n`=1, `spi_sclk`=0. `busy` rises in the cycle after a command is accepted. `done` is a one-cycle pulse, issued in the same cycle that `busy` falls.
- R2: While `busy` is high, `cmd_valid` has no effect. No extra frame is sent, and `busy` falls once the running command finishes.
- R3: SPI mode: `spi_sclk` idles low. MOSI changes only on the falling edge and MISO is sampled on the rising edge. Bytes are shifted MSB first. Each high phase of `spi_sclk` lasts exactly `clk_div+1` cycles.
- R4: A read frame sends opcode 0x03, then the block index high byte, the block index low byte, and 0x00.
- R5: A read frame then clocks 256 filler bytes of 0xFF. Each received byte is written to the buffer, in order, at offsets 0 to 255.
- R6: A write starts with a status-read frame (0x05, then one 0xFF filler byte). If status bit 7, 3 or 2 is set, a status-write frame follows (0x01, then the status with bits 7, 3 and 2 cleared). Otherwise that frame is skipped.
- R7: Next comes a one-byte write-enable frame (0x06) with its own chip-select pulse. Then the write frame: 0x02, the address bytes as in R4, and buffer bytes 0 to 255 in order.
- R8: After the write frame, status-read frames repeat until status bit 0 reads 0. Only then is `done` raised.
- R9: At least GUARD cycles separate every chip-select edge from any `spi_sclk` edge. `spi_sclk` never toggles while chip select is high.
- R10: Every frame has exactly eight `spi_sclk` rising edges per byte. Chip select rises only after the last bit of the last byte has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Serial clock phase length minus one, in system cycles |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_write | input | 1 | 1 = block write, 0 = block read |
| cmd_block | input | 16 | Block index |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| buf_addr | output | 8 | Buffer byte offset |
| buf_wr_en | output | 1 | Buffer write strobe (read data) |
| buf_wr_data | output | 8 | Byte received from the device |
| buf_rd_data | input | 8 | Buffer byte at `buf_addr`, combinational |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
`busy` is due one cycle after the accepting edge, so the bench samples it on the falling edge right after the strobe. `done` is due GUARD+1 cycles after the last chip-select rise plus a guard stage, so the bench polls on every falling edge and checks `busy` in that same sample. The serial side is checked by a device model that samples on falling system-clock edges. There it counts the cycles between `spi_sclk` and chip-select edges against `clk_div+1` and GUARD. It logs each frame's opcode, header and data, which the bench compares with the expected frame lists once `done` arrives.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] FILL     = 8'hFF;
  localparam int         ST_WIP   = 0;
  localparam logic [7:0] PROT_MASK = 8'h8C;
  localparam int         BLK_BYTES = 256;
  localparam int         HDR_BYTES = 4;

  typedef enum logic [2:0] {
    FR_CHECK, FR_UNLOCK, FR_ENABLE, FR_PROGRAM, FR_POLL, FR_FETCH
  } frame_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LEAD_A, SQ_LEAD_B, SQ_LAUNCH, SQ_SHIFT, SQ_TAIL_A, SQ_TAIL_B
  } seq_e;
endpackage

// File: rtl/eeseq_guard.sv
module eeseq_guard #(
  parameter int GUARD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(GUARD + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GUARD - 1);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || expired) cnt_d = '0;
    else                 cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eeseq_shifter.sv
module eeseq_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             active,
  output logic             done,
  output logic [7:0]       rx_byte
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic             active_q, active_d;
  logic [DIV_W-1:0] half_q, half_d;
  logic [3:0]       edge_q, edge_d;
  logic             sclk_q, sclk_d;
  logic [7:0]       tx_q, tx_d;
  logic [7:0]       rx_q, rx_d;
  logic             done_q, done_d;

  always_comb begin
    active_d = active_q;
    half_d   = half_q;
    edge_d   = edge_q;
    sclk_d   = sclk_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    if (!active_q) begin
      if (start) begin
        active_d = 1'b1;
        half_d   = '0;
        edge_d   = 4'd0;
        sclk_d   = 1'b0;
        tx_d     = tx_byte;
      end
    end else if (half_q == div) begin
      half_d = '0;
      edge_d = edge_q + 4'd1;
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[6:0], miso};
      end else begin
        sclk_d = 1'b0;
        tx_d   = {tx_q[6:0], 1'b1};
      end
      if (edge_q == 4'd15) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end
    end else begin
      half_d = half_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      half_q   <= '0;
      edge_q   <= 4'd0;
      sclk_q   <= 1'b0;
      tx_q     <= 8'hFF;
      rx_q     <= 8'h00;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      half_q   <= half_d;
      edge_q   <= edge_d;
      sclk_q   <= sclk_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      done_q   <= done_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[7];
  assign active  = active_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !sclk_q) else $error("sclk not idle low");

  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(tx_q[7])) else $error("mosi moved while sclk high");

  p_done_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!sclk_q && !active_q)) else $error("byte done before final falling edge");
endmodule

// File: rtl/eeseq_ctrl.sv
module eeseq_ctrl
  import eeseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_write,
  input  logic [15:0] cmd_block,
  output logic        busy,
  output logic        done,
  output logic        eng_start,
  output logic [7:0]  eng_tx,
  input  logic        eng_done,
  input  logic        eng_active,
  input  logic [7:0]  eng_rx,
  output logic        guard_run,
  input  logic        guard_expired,
  output logic        cs_n,
  output logic [7:0]  buf_addr,
  output logic        buf_wr_en,
  output logic [7:0]  buf_wr_data,
  input  logic [7:0]  buf_rd_data
);
  localparam int FRAME_MAX = HDR_BYTES + BLK_BYTES;
  localparam int IDX_W     = $clog2(FRAME_MAX + 1);
  localparam logic [IDX_W-1:0] I_ONE  = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_TWO  = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_THR  = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_HDR  = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] I_LAST = IDX_W'(FRAME_MAX - 1);

  seq_e             state_q, state_d;
  frame_e           frame_q, frame_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [15:0]      blk_q, blk_d;
  logic [7:0]       stat_q, stat_d;
  logic             cs_q, cs_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] data_off;

  always_comb begin
    case (frame_q)
      FR_ENABLE:                     last_idx = '0;
      FR_CHECK, FR_UNLOCK, FR_POLL:  last_idx = I_ONE;
      default:                       last_idx = I_LAST;
    endcase
  end

  assign data_off = idx_q - I_HDR;

  always_comb begin
    eng_tx = FILL;
    if (idx_q == '0) begin
      case (frame_q)
        FR_CHECK, FR_POLL: eng_tx = OP_RDSR;
        FR_UNLOCK:         eng_tx = OP_WRSR;
        FR_ENABLE:         eng_tx = OP_WREN;
        FR_PROGRAM:        eng_tx = OP_WRITE;
        default:           eng_tx = OP_READ;
      endcase
    end else if (idx_q == I_ONE) begin
      case (frame_q)
        FR_UNLOCK:            eng_tx = stat_q & ~PROT_MASK;
        FR_PROGRAM, FR_FETCH: eng_tx = blk_q[15:8];
        default:              eng_tx = FILL;
      endcase
    end else if (idx_q == I_TWO) begin
      eng_tx = blk_q[7:0];
    end else if (idx_q == I_THR) begin
      eng_tx = 8'h00;
    end else if (frame_q == FR_PROGRAM) begin
      eng_tx = buf_rd_data;
    end
  end

  always_comb begin
    state_d = state_q;
    frame_d = frame_q;
    idx_d   = idx_q;
    blk_d   = blk_q;
    stat_d  = stat_q;
    cs_d    = cs_q;
    done_d  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (cmd_valid) begin
          frame_d = cmd_write ? FR_CHECK : FR_FETCH;
          blk_d   = cmd_block;
          state_d = SQ_LEAD_A;
        end
      end
      SQ_LEAD_A: begin
        if (guard_expired) begin
          cs_d    = 1'b0;
          state_d = SQ_LEAD_B;
        end
      end
      SQ_LEAD_B: begin
        if (guard_expired) begin
          idx_d   = '0;
          state_d = SQ_LAUNCH;
        end
      end
      SQ_LAUNCH: state_d = SQ_SHIFT;
      SQ_SHIFT: begin
        if (eng_done) begin
          if ((frame_q == FR_CHECK || frame_q == FR_POLL) && idx_q == I_ONE)
            stat_d = eng_rx;
          if (idx_q == last_idx) begin
            state_d = SQ_TAIL_A;
          end else begin
            idx_d   = idx_q + I_ONE;
            state_d = SQ_LAUNCH;
          end
        end
      end
      SQ_TAIL_A: begin
        if (guard_expired) begin
          cs_d    = 1'b1;
          state_d = SQ_TAIL_B;
        end
      end
      SQ_TAIL_B: begin
        if (guard_expired) begin
          state_d = SQ_LEAD_A;
          case (frame_q)
            FR_CHECK:   frame_d = ((stat_q & PROT_MASK) != 8'h00) ? FR_UNLOCK : FR_ENABLE;
            FR_UNLOCK:  frame_d = FR_ENABLE;
            FR_ENABLE:  frame_d = FR_PROGRAM;
            FR_PROGRAM: frame_d = FR_POLL;
            FR_POLL: begin
              if (!stat_q[ST_WIP]) begin
                state_d = SQ_IDLE;
                done_d  = 1'b1;
              end
            end
            default: begin
              state_d = SQ_IDLE;
              done_d  = 1'b1;
            end
          endcase
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      frame_q <= FR_FETCH;
      idx_q   <= '0;
      blk_q   <= 16'h0000;
      stat_q  <= 8'h00;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      frame_q <= frame_d;
      idx_q   <= idx_d;
      blk_q   <= blk_d;
      stat_q  <= stat_d;
      cs_q    <= cs_d;
      done_q  <= done_d;
    end
  end

  assign busy        = (state_q != SQ_IDLE);
  assign done        = done_q;
  assign cs_n        = cs_q;
  assign eng_start   = (state_q == SQ_LAUNCH);
  assign guard_run   = (state_q == SQ_LEAD_A) || (state_q == SQ_LEAD_B) ||
                       (state_q == SQ_TAIL_A) || (state_q == SQ_TAIL_B);
  assign buf_addr    = data_off[7:0];
  assign buf_wr_en   = (state_q == SQ_SHIFT) && eng_done && (frame_q == FR_FETCH) &&
                       (idx_q >= I_HDR);
  assign buf_wr_data = eng_rx;

  p_launch_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_active) else $error("byte launched mid-transfer");

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle");

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy) else $error("busy missing after accept");

  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> $stable(blk_q)) else $error("command taken while busy");

  p_unlock_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && frame_q == FR_UNLOCK && idx_q == I_ONE) |-> ((eng_tx & PROT_MASK) == 8'h00))
    else $error("protection bits not cleared");

  p_cs_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |-> !cs_q) else $error("chip select high during byte");
endmodule

// File: rtl/eeprom_block_sequencer.sv
module eeprom_block_sequencer #(
  parameter int DIV_W = 8,
  parameter int GUARD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [15:0]      cmd_block,
  output logic             busy,
  output logic             done,
  output logic [7:0]       buf_addr,
  output logic             buf_wr_en,
  output logic [7:0]       buf_wr_data,
  input  logic [7:0]       buf_rd_data,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic       eng_start, eng_done, eng_active;
  logic [7:0] eng_tx, eng_rx;
  logic       guard_run, guard_expired;

  eeseq_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .cmd_valid     (cmd_valid),
    .cmd_write     (cmd_write),
    .cmd_block     (cmd_block),
    .busy          (busy),
    .done          (done),
    .eng_start     (eng_start),
    .eng_tx        (eng_tx),
    .eng_done      (eng_done),
    .eng_active    (eng_active),
    .eng_rx        (eng_rx),
    .guard_run     (guard_run),
    .guard_expired (guard_expired),
    .cs_n          (spi_cs_n),
    .buf_addr      (buf_addr),
    .buf_wr_en     (buf_wr_en),
    .buf_wr_data   (buf_wr_data),
    .buf_rd_data   (buf_rd_data)
  );

  eeseq_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .div     (clk_div),
    .start   (eng_start),
    .tx_byte (eng_tx),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .active  (eng_active),
    .done    (eng_done),
    .rx_byte (eng_rx)
  );

  eeseq_guard #(.GUARD(GUARD)) u_guard (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (guard_run),
    .expired (guard_expired)
  );

  p_cs_quiet_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    spi_cs_n |-> !spi_sclk) else $error("sclk active with chip select high");
endmodule

// File: tb/eeprom_block_sequencer_bench.sv
module eeprom_block_sequencer_bench;
  localparam int DIV_W = 8;
  localparam int GUARD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [DIV_W-1:0] clk_div = '0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_block = 16'h0;
  logic        busy, done, buf_wr_en, spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b1;
  logic [7:0]  buf_addr, buf_wr_data, buf_rd_data;

  logic [7:0] src_buf [0:255];
  logic [7:0] dst_buf [0:255];
  assign buf_rd_data = src_buf[buf_addr];

  eeprom_block_sequencer #(.DIV_W(DIV_W), .GUARD(GUARD)) u_eeprom_block_sequencer (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_block(cmd_block), .busy(busy), .done(done),
    .buf_addr(buf_addr), .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
    .buf_rd_data(buf_rd_data), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_checks = 0;
  int n_fail = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) ^ (i >> 8));
  endfunction

  // buffer write side: order and count
  int wr_cnt = 0, wr_order_err = 0;
  always @(posedge clk) begin
    if (buf_wr_en) begin
      dst_buf[buf_addr] <= buf_wr_data;
      if (int'(buf_addr) != (wr_cnt % 256)) wr_order_err++;
      wr_cnt++;
    end
  end

  // device model configuration, written by the stimulus only
  logic [7:0] cfg_prot = 8'h00;
  int         cfg_polls = 0;
  int         apply_req = 0;

  // device model state, written by the model only
  int         apply_ack = 0;
  bit         mem_ready = 1'b0;
  logic [7:0] mem [0:1023];
  logic [7:0] wb  [0:255];
  logic [7:0] log_op [0:63];
  int         log_n = 0;
  logic [7:0] st_prot = 8'h00;
  bit         wel = 1'b0;
  int         wip_left = 0;
  logic [7:0] ahi = 8'h00, alo = 8'h00, a0 = 8'hAA, wrsr_val = 8'h55, op = 8'h00;
  logic [7:0] in_sr = 8'h00, out_sr = 8'hFF;
  int         bitc = 0, nbytes = 0, rises = 0, commits = 0;
  int         frame_err = 0, guard_err = 0, hp_err = 0, fill_err = 0;
  int         since_cs = 1000, since_sclk = 1000;
  logic       p_cs = 1'b1, p_sclk = 1'b0;

  function automatic logic [7:0] status_now();
    return {st_prot[7], 3'b000, st_prot[3:2], wel, (wip_left != 0)};
  endfunction

  task automatic byte_in(logic [7:0] b);
    if (nbytes == 0) begin
      op = b;
      log_op[log_n % 64] = b;
      log_n++;
      out_sr = (b == 8'h05) ? status_now() : 8'hFF;
    end else begin
      case (op)
        8'h01: if (nbytes == 1) begin wrsr_val = b; st_prot = b & 8'h8C; end
        8'h05: if (b != 8'hFF) fill_err++;
        8'h03, 8'h02: begin
          if (nbytes == 1) ahi = b;
          else if (nbytes == 2) alo = b;
          else if (nbytes == 3) a0 = b;
          if (op == 8'h03) begin
            if (nbytes >= 4 && b != 8'hFF) fill_err++;
            if (nbytes >= 3 && nbytes <= 258)
              out_sr = mem[{alo[1:0], 8'(nbytes - 3)}];
          end else if (nbytes >= 4 && nbytes <= 259) begin
            wb[nbytes - 4] = b;
          end
        end
        default: ;
      endcase
    end
    nbytes++;
  endtask

  task automatic frame_end();
    if (rises != 8 * nbytes) frame_err++;
    case (op)
      8'h06: if (nbytes == 1) wel = 1'b1;
      8'h02: begin
        if (wel && st_prot == 8'h00 && nbytes == 260) begin
          for (int i = 0; i < 256; i++) mem[{alo[1:0], 8'(i)}] = wb[i];
          commits++;
          wip_left = cfg_polls;
        end
        wel = 1'b0;
      end
      8'h05: if (wip_left > 0) wip_left--;
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    if (apply_req != apply_ack) begin
      st_prot = cfg_prot & 8'h8C;
      if (!mem_ready) begin
        for (int i = 0; i < 1024; i++) mem[i] = pat(i);
        mem_ready = 1'b1;
      end
      apply_ack = apply_req;
    end
    if (rst_n) begin
      since_cs++;
      since_sclk++;
      if (spi_cs_n !== p_cs) begin
        if (since_sclk < GUARD) guard_err++;
        since_cs = 0;
        if (!spi_cs_n) begin
          bitc = 0; nbytes = 0; rises = 0; out_sr = 8'hFF; op = 8'h00;
        end else begin
          frame_end();
        end
      end
      if (spi_sclk !== p_sclk) begin
        if (since_cs < GUARD || spi_cs_n) guard_err++;
        if (spi_sclk) begin
          rises++;
          in_sr = {in_sr[6:0], spi_mosi};
          bitc++;
          if (bitc == 8) begin
            bitc = 0;
            byte_in(in_sr);
          end
        end else begin
          // R3: high phase length equals clk_div+1
          if (since_sclk != int'(clk_div) + 1) hp_err++;
          spi_miso = out_sr[7];
          out_sr = {out_sr[6:0], 1'b1};
        end
        since_sclk = 0;
      end
      p_cs = spi_cs_n;
      p_sclk = spi_sclk;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply_cfg(logic [7:0] prot, int polls);
    cfg_prot = prot;
    cfg_polls = polls;
    apply_req++;
    repeat (3) @(negedge clk);
  endtask

  task automatic issue(bit wr, logic [15:0] blk);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_block = blk;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R1 busy one cycle after accept", int'(busy), 1);
  endtask

  task automatic wait_done();
    int cyc = 0;
    while (done !== 1'b1 && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R1 done arrived", int'(done === 1'b1), 1);
    chk("R1 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk("R1 done one cycle", int'(done), 0);
  endtask

  task automatic chk_log(string tag, int base, int idx, logic [7:0] exp);
    chk(tag, int'(log_op[(base + idx) % 64]), int'(exp));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    int base, mism;
    logic [15:0] blk;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset cs_n", int'(spi_cs_n), 1);
    chk("R1 reset sclk", int'(spi_sclk), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply_cfg(8'h00, 0);

    for (int d = 0; d < 3; d += 2) begin
      clk_div = DIV_W'(d);

      // block read, with an ignored command in the middle
      blk = 16'hA301 + 16'(d);
      base = log_n;
      wr_cnt = 0;
      issue(1'b0, blk);
      repeat (30) @(negedge clk);
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_block = 16'h0003;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done();
      repeat (20) @(negedge clk);
      chk("R2 no frame from ignored command", log_n - base, 1);
      chk("R2 idle after run", int'(busy), 0);
      chk_log("R4 read opcode", base, 0, 8'h03);
      chk("R4 addr high", int'(ahi), int'(blk[15:8]));
      chk("R4 addr low", int'(alo), int'(blk[7:0]));
      chk("R4 addr third byte", int'(a0), 0);
      chk("R5 buffer write count", wr_cnt, 256);
      chk("R5 buffer write order", wr_order_err, 0);
      mism = 0;
      for (int i = 0; i < 256; i++)
        if (dst_buf[i] !== mem[{blk[1:0], 8'(i)}]) mism++;
      chk("R5 R3 read data msb first", mism, 0);
      chk("R5 filler bytes", fill_err, 0);

      // protected write with busy polling
      for (int i = 0; i < 256; i++) src_buf[i] = 8'(i ^ 8'h5A ^ d);
      apply_cfg(8'h88, 3);
      blk = 16'h0042 + 16'(d);
      base = log_n;
      issue(1'b1, blk);
      wait_done();
      chk("R8 frame count protected write", log_n - base, 8);
      chk_log("R6 status read first", base, 0, 8'h05);
      chk_log("R6 status write", base, 1, 8'h01);
      chk_log("R7 write enable", base, 2, 8'h06);
      chk_log("R7 write opcode", base, 3, 8'h02);
      for (int k = 4; k < 8; k++) chk_log("R8 poll frame", base, k, 8'h05);
      chk("R6 cleared status value", int'(wrsr_val), 0);
      chk("R4 write addr low", int'(alo), int'(blk[7:0]));
      mism = 0;
      for (int i = 0; i < 256; i++)
        if (mem[{blk[1:0], 8'(i)}] !== src_buf[i]) mism++;
      chk("R7 written data", mism, 0);

      // unprotected write, no busy time
      for (int i = 0; i < 256; i++) src_buf[i] = 8'(255 - i + d);
      apply_cfg(8'h00, 0);
      blk = 16'h7F10 + 16'(d);
      base = log_n;
      issue(1'b1, blk);
      wait_done();
      chk("R6 unlock skipped frame count", log_n - base, 4);
      chk_log("R6 status read", base, 0, 8'h05);
      chk_log("R7 enable after status", base, 1, 8'h06);
      chk_log("R7 write", base, 2, 8'h02);
      chk_log("R8 single poll", base, 3, 8'h05);
      mism = 0;
      for (int i = 0; i < 256; i++)
        if (mem[{blk[1:0], 8'(i)}] !== src_buf[i]) mism++;
      chk("R7 written data unprotected", mism, 0);
      chk("R3 sclk high phase", hp_err, 0);
      chk("R9 guard spacing", guard_err, 0);
      chk("R10 eight clocks per byte", frame_err, 0);
      chk("R1 cs idle high", int'(spi_cs_n), 1);
    end
    chk("R7 commit count", commits, 4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule